// File: doc/BRIEF.md
# Dual-Port Serial Memory Address Router

This block sits between a chip's address sources and a controller that drives two serial memory devices. A flat address arrives from one of two paths. The direct command path presents a plain device offset. The memory-mapped path presents an address inside a fixed window, and the block subtracts the window base from it first. The block then decides which device the offset belongs to. Device A always claims the lowest part of the offset space. Device B is placed directly above device A's configured span, so device B's location moves whenever device A's size changes. The result is one registered routing decision: a port select, the address local to that device, and an out-of-range flag for offsets that neither device covers.

Software programs each device's size as a count of kilobytes, and the block multiplies that count by 1024 to get a byte span. A small region table sits beside the router. Each entry holds an upper boundary offset and a policy code. The first region whose boundary lies above the offset supplies the policy code for the access, and a downstream cache uses that code. Size changes are held back while requests are streaming, so a burst of requests always sees a single consistent map.

Top module: `twin_port_addr_map`

## Requirements
- R1: After reset, every output is 0 and both sizes are 0, so the first request is flagged out of range. Whenever out_valid is 0, the select, flag, address and policy outputs are 0.
- R2: An offset below the device A span (size_a_kb × 1024) raises out_sel_a, and out_dev_addr equals the offset.
- R3: An offset that is at least the device A span but below the device A span plus the device B span raises out_sel_b, and out_dev_addr equals the offset minus the device A span.
- R4: When size A is 0, device B starts at offset 0.
- R5: An offset at or above the combined span raises out_oor, lowers both selects, and drives out_dev_addr and out_policy to 0.
- R6: With in_mapped=1, the offset is in_addr − MAP_BASE, and the same split as for the direct path applies. An in_addr below MAP_BASE is out of range. With in_mapped=0, the offset is in_addr.
- R7: Each request with in_valid=1 produces exactly one result with out_valid=1 on the next cycle. Back-to-back requests give back-to-back results.
- R8: A size write made in a cycle with in_valid=1 is held and does not change routing until the first later cycle with in_valid=0. From the cycle after that cycle, the new size is in force. A size write in a cycle with in_valid=0 is in force from the next cycle.
- R9: The policy code is taken from the lowest-numbered region k whose boundary is above the offset. If no boundary is above the offset, the code is 0. Boundary and policy writes are in force from the next cycle, whatever in_valid is.
- R10: Configuration index 0 holds the size A count in kilobytes (cfg_wdata[SIZE_W-1:0]). Index 1 holds the size B count. Index 2+2k holds the boundary of region k (all of cfg_wdata). Index 3+2k holds the policy of region k (cfg_wdata[POLICY_W-1:0]). Writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | CFG_AW | Configuration slot index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| in_valid | input | 1 | Request present this cycle |
| in_mapped | input | 1 | 1: memory-mapped window address; 0: direct offset |
| in_addr | input | ADDR_W | Request address |
| out_valid | output | 1 | Routing result present |
| out_sel_a | output | 1 | Request goes to device A |
| out_sel_b | output | 1 | Request goes to device B |
| out_oor | output | 1 | Request is outside both devices |
| out_dev_addr | output | ADDR_W | Address local to the selected device |
| out_policy | output | POLICY_W | Policy code of the matching region |

## Verification
The bench keeps the default parameters: a 32-bit address, a 20-bit kilobyte count, two regions, 2-bit policy codes and a window base of 0x28000000. With these values it can program a realistic 64 MB device A (0x10000 KB) and an 8 MB device B (0x2000 KB). Every edge of the map can then be hit exactly: 0x3FFFFFF, 0x4000000, 0x47FFFFF and 0x4800000 on the direct path, and 0x2C000000 and 0x2C800000 through the window. The bench also shrinks device A in the middle of a stream and sets device A to zero, which moves device B's start while requests are in flight.

// File: rtl/tpam_pkg.sv
package tpam_pkg;
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_A    = 2'd1,
      ROUTE_B    = 2'd2,
      ROUTE_OOR  = 2'd3
   } route_e;

   localparam int KB_SHIFT = 10;
endpackage

// File: rtl/tpam_size_cfg.sv
module tpam_size_cfg #(
   parameter int SIZE_W = 20
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        busy,
   input  logic [1:0]                  wr,
   input  logic [SIZE_W-1:0]           wdata,
   output logic [1:0][SIZE_W-1:0]      act
);
   for (genvar g = 0; g < 2; g++) begin : g_port
      logic [SIZE_W-1:0] shadow;
      logic              pend;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act[g] <= '0;
            shadow <= '0;
            pend   <= 1'b0;
         end else if (busy) begin
            if (wr[g]) begin
               shadow <= wdata;
               pend   <= 1'b1;
            end
         end else begin
            if (wr[g])
               act[g] <= wdata;
            else if (pend)
               act[g] <= shadow;
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tpam_port_select.sv
module tpam_port_select import tpam_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 20
) (
   input  logic [ADDR_W:0]        off,
   input  logic                   off_ok,
   input  logic [SIZE_W-1:0]      size_a,
   input  logic [SIZE_W-1:0]      size_b,
   output route_e                 route,
   output logic [ADDR_W-1:0]      dev
);
   localparam int OFF_W = ADDR_W + 1;

   logic [OFF_W-1:0] span_a, span_b, end_b;

   assign span_a = OFF_W'(size_a) << KB_SHIFT;
   assign span_b = OFF_W'(size_b) << KB_SHIFT;
   assign end_b  = span_a + span_b;

   always_comb begin
      route = ROUTE_OOR;
      dev   = '0;
      if (off_ok) begin
         if (off < span_a) begin
            route = ROUTE_A;
            dev   = off[ADDR_W-1:0];
         end else if (off < end_b) begin
            route = ROUTE_B;
            dev   = ADDR_W'(off - span_a);
         end
      end
   end
endmodule

// File: rtl/tpam_region_lookup.sv
module tpam_region_lookup #(
   parameter int ADDR_W      = 32,
   parameter int NUM_REGIONS = 2,
   parameter int POLICY_W    = 2
) (
   input  logic [ADDR_W:0]                        off,
   input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]     bnd,
   input  logic [NUM_REGIONS-1:0][POLICY_W-1:0]   pol,
   output logic [POLICY_W-1:0]                    pol_out
);
   logic [NUM_REGIONS-1:0] hit;

   for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_cmp
      assign hit[k] = off < {1'b0, bnd[k]};
   end

   always_comb begin
      pol_out = '0;
      for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
         if (hit[k])
            pol_out = pol[k];
      end
   end
endmodule

// File: rtl/twin_port_addr_map.sv
module twin_port_addr_map import tpam_pkg::*; #(
   parameter int          ADDR_W      = 32,
   parameter int          SIZE_W      = 20,
   parameter int          NUM_REGIONS = 2,
   parameter int          POLICY_W    = 2,
   parameter logic [31:0] MAP_BASE    = 32'h2800_0000,
   localparam int         CFG_AW      = $clog2(2 + 2 * NUM_REGIONS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_idx,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic                 in_valid,
   input  logic                 in_mapped,
   input  logic [ADDR_W-1:0]    in_addr,
   output logic                 out_valid,
   output logic                 out_sel_a,
   output logic                 out_sel_b,
   output logic                 out_oor,
   output logic [ADDR_W-1:0]    out_dev_addr,
   output logic [POLICY_W-1:0]  out_policy
);
   localparam int OFF_W = ADDR_W + 1;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MAP_BASE);

   if (SIZE_W + KB_SHIFT > ADDR_W) begin : g_chk_size
      $error("twin_port_addr_map: SIZE_W too wide for ADDR_W");
   end
   if (NUM_REGIONS < 1) begin : g_chk_reg
      $error("twin_port_addr_map: NUM_REGIONS must be at least 1");
   end
   if (POLICY_W < 1 || POLICY_W > ADDR_W) begin : g_chk_pol
      $error("twin_port_addr_map: POLICY_W out of range");
   end

   logic [1:0]                          size_wr;
   logic [1:0][SIZE_W-1:0]              act_size;
   logic [NUM_REGIONS-1:0][ADDR_W-1:0]  bnd_q;
   logic [NUM_REGIONS-1:0][POLICY_W-1:0] pol_q;

   assign size_wr[0] = cfg_we && (cfg_idx == CFG_AW'(0));
   assign size_wr[1] = cfg_we && (cfg_idx == CFG_AW'(1));

   tpam_size_cfg #(.SIZE_W(SIZE_W)) u_size (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (in_valid),
      .wr    (size_wr),
      .wdata (cfg_wdata[SIZE_W-1:0]),
      .act   (act_size)
   );

   for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bnd_q[k] <= '0;
            pol_q[k] <= '0;
         end else if (cfg_we) begin
            if (cfg_idx == CFG_AW'(2 + 2 * k))
               bnd_q[k] <= cfg_wdata;
            if (cfg_idx == CFG_AW'(3 + 2 * k))
               pol_q[k] <= cfg_wdata[POLICY_W-1:0];
         end
      end
   end

   logic [OFF_W-1:0] off;
   logic             off_ok;

   always_comb begin
      if (in_mapped) begin
         off_ok = in_addr >= BASE;
         off    = {1'b0, in_addr - BASE};
      end else begin
         off_ok = 1'b1;
         off    = {1'b0, in_addr};
      end
   end

   route_e              route;
   logic [ADDR_W-1:0]   dev;
   logic [POLICY_W-1:0] pol_hit;

   tpam_port_select #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_sel (
      .off    (off),
      .off_ok (off_ok),
      .size_a (act_size[0]),
      .size_b (act_size[1]),
      .route  (route),
      .dev    (dev)
   );

   tpam_region_lookup #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .POLICY_W(POLICY_W)
   ) u_reg (
      .off     (off),
      .bnd     (bnd_q),
      .pol     (pol_q),
      .pol_out (pol_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !in_valid) begin
         out_valid    <= 1'b0;
         out_sel_a    <= 1'b0;
         out_sel_b    <= 1'b0;
         out_oor      <= 1'b0;
         out_dev_addr <= '0;
         out_policy   <= '0;
      end else begin
         out_valid    <= 1'b1;
         out_sel_a    <= route == ROUTE_A;
         out_sel_b    <= route == ROUTE_B;
         out_oor      <= route == ROUTE_OOR;
         out_dev_addr <= dev;
         out_policy   <= (route == ROUTE_OOR) ? '0 : pol_hit;
      end
   end
endmodule

// File: rtl/twin_port_addr_map_chk.sv
module twin_port_addr_map_chk #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 20,
   parameter int POLICY_W = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic                   out_sel_a,
   input logic                   out_sel_b,
   input logic                   out_oor,
   input logic [ADDR_W-1:0]      out_dev_addr,
   input logic [POLICY_W-1:0]    out_policy,
   input logic [1:0][SIZE_W-1:0] act_size
);
   logic [ADDR_W:0] span_a, span_b;
   assign span_a = (ADDR_W + 1)'(act_size[0]) << 10;
   assign span_b = (ADDR_W + 1)'(act_size[1]) << 10;

   p_lat_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_lat_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_sel_a && !out_sel_b && !out_oor && out_dev_addr == '0 && out_policy == '0));
   p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones({out_sel_a, out_sel_b, out_oor}) == 1);
   p_oor_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_oor |-> (out_dev_addr == '0 && out_policy == '0));
   p_a_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_sel_a |-> {1'b0, out_dev_addr} < span_a);
   p_b_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_sel_b |-> {1'b0, out_dev_addr} < span_b);
   p_hold_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $stable(act_size));
endmodule

bind twin_port_addr_map twin_port_addr_map_chk #(
   .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .POLICY_W(POLICY_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .out_sel_a    (out_sel_a),
   .out_sel_b    (out_sel_b),
   .out_oor      (out_oor),
   .out_dev_addr (out_dev_addr),
   .out_policy   (out_policy),
   .act_size     (act_size)
);

// File: tb/sim_twin_port_addr_map.sv
module sim_twin_port_addr_map;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int SW = 20;
   localparam int NR = 2;
   localparam int PW = 2;
   localparam longint BASE = 64'h2800_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          in_valid = 1'b0;
   logic          in_mapped = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          out_valid, out_sel_a, out_sel_b, out_oor;
   logic [AW-1:0] out_dev_addr;
   logic [PW-1:0] out_policy;

   always #(CLK_PERIOD / 2) clk = ~clk;

   twin_port_addr_map u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_mapped(in_mapped),
      .in_addr(in_addr), .out_valid(out_valid), .out_sel_a(out_sel_a),
      .out_sel_b(out_sel_b), .out_oor(out_oor), .out_dev_addr(out_dev_addr),
      .out_policy(out_policy)
   );

   typedef struct {
      logic   a, b, oor;
      longint dev;
      int     pol;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   int     total = 0;
   int     bad = 0;
   bit     done = 1'b0;

   // bench model of the configuration
   longint m_act[2], m_shd[2];
   bit     m_pend[2];
   longint m_bnd[NR];
   int     m_pol[NR];

   function automatic exp_t predict(bit mapped, longint addr);
      exp_t e;
      longint off, sa, sb_;
      bit ok;
      e.a = 0; e.b = 0; e.oor = 1; e.dev = 0; e.pol = 0;
      ok  = !mapped || addr >= BASE;
      off = mapped ? addr - BASE : addr;
      sa  = m_act[0] * 1024;
      sb_ = m_act[1] * 1024;
      if (ok && off < sa) begin
         e.a = 1; e.oor = 0; e.dev = off; e.tag = "R2";
      end else if (ok && off < sa + sb_) begin
         e.b = 1; e.oor = 0; e.dev = off - sa; e.tag = "R3";
      end else begin
         e.tag = "R5";
      end
      if (!e.oor) begin
         for (int k = NR - 1; k >= 0; k--)
            if (off < m_bnd[k]) e.pol = m_pol[k];
      end
      return e;
   endfunction

   // driver: one cycle of stimulus, with model update per R8/R9/R10
   task automatic cyc(bit v, bit mapped, longint addr, bit we, int idx, longint data);
      in_valid  = v;
      in_mapped = mapped;
      in_addr   = AW'(addr);
      cfg_we    = we;
      cfg_idx   = 3'(idx);
      cfg_wdata = AW'(data);
      if (v) sb.push_back(predict(mapped, addr));
      for (int p = 0; p < 2; p++) begin
         bit w;
         w = we && idx == p;
         if (v) begin
            if (w) begin m_shd[p] = data & 64'hF_FFFF; m_pend[p] = 1; end
         end else begin
            if (w) m_act[p] = data & 64'hF_FFFF;
            else if (m_pend[p]) m_act[p] = m_shd[p];
            m_pend[p] = 0;
         end
      end
      for (int k = 0; k < NR; k++) begin
         if (we && idx == 2 + 2 * k) m_bnd[k] = data & 64'hFFFF_FFFF;
         if (we && idx == 3 + 2 * k) m_pol[k] = int'(data & 3);
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      cfg_we   = 1'b0;
   endtask

   task automatic req(bit mapped, longint addr);
      cyc(1, mapped, addr, 0, 0, 0);
   endtask

   task automatic wr(int idx, longint data);
      cyc(0, 0, 0, 1, idx, data);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            total++;
            if (sb.size() == 0) begin
               bad++;
               $display("FAIL R7: result without request, actual out_valid=1 expected 0");
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (out_sel_a !== e.a || out_sel_b !== e.b || out_oor !== e.oor ||
                   longint'(out_dev_addr) != e.dev || int'(out_policy) != e.pol) begin
                  bad++;
                  $display("FAIL %s: actual a=%0b b=%0b oor=%0b dev=%h pol=%0d expected a=%0b b=%0b oor=%0b dev=%h pol=%0d",
                           e.tag, out_sel_a, out_sel_b, out_oor, out_dev_addr, out_policy,
                           e.a, e.b, e.oor, e.dev, e.pol);
               end
            end
         end else if (out_sel_a || out_sel_b || out_oor || out_dev_addr != '0 || out_policy != '0) begin
            total++;
            bad++;
            $display("FAIL R1: idle outputs actual a=%0b b=%0b oor=%0b dev=%h pol=%0d expected all 0",
                     out_sel_a, out_sel_b, out_oor, out_dev_addr, out_policy);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      for (int p = 0; p < 2; p++) begin m_act[p] = 0; m_shd[p] = 0; m_pend[p] = 0; end
      for (int k = 0; k < NR; k++) begin m_bnd[k] = 0; m_pol[k] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      total++;
      if (out_valid || out_sel_a || out_sel_b || out_oor || out_dev_addr != '0 || out_policy != '0) begin
         bad++;
         $display("FAIL R1: after reset actual v=%0b a=%0b b=%0b oor=%0b expected all 0",
                  out_valid, out_sel_a, out_sel_b, out_oor);
      end
      @(posedge clk); #1;
      // R1: zero sizes -> out of range
      req(0, 0);
      idle(1);

      // R10: map layout, sizes 64 MB / 8 MB, regions with distinct codes (R9)
      wr(0, 64'h1_0000);
      wr(1, 64'h2000);
      wr(2, 64'h400_0000);
      wr(3, 1);
      wr(4, 64'h480_0000);
      wr(5, 2);
      idle(1);

      // R2 R3 R5: direct path around the edges, back to back (R7)
      req(0, 64'h0);
      req(0, 64'h3FF_FFFF);
      req(0, 64'h400_0000);
      req(0, 64'h47F_FFFF);
      req(0, 64'h480_0000);
      req(0, 64'hFFFF_FFFF);
      idle(1);

      // R6: mapped window
      req(1, 64'h2800_0010);
      req(1, 64'h2C00_0000);
      req(1, 64'h2C7F_FFFC);
      req(1, 64'h2C80_0000);
      req(1, 64'h27FF_FFFF);
      idle(1);

      // R9: boundary moved while busy takes effect at once; beyond all -> 0
      cyc(1, 0, 64'h10, 1, 2, 64'h20);
      req(0, 64'h10);
      req(0, 64'h20);
      wr(4, 64'h30);
      req(0, 64'h40);
      wr(2, 64'h400_0000);
      wr(4, 64'h480_0000);
      idle(1);

      // R8: size A shrunk mid-stream stays deferred until an idle cycle
      cyc(1, 0, 64'h400_0000, 1, 0, 64'h100);
      req(0, 64'h400_0000);
      req(0, 64'h3_FFFF);
      idle(1);
      req(0, 64'h3_FFFF);
      req(0, 64'h4_0000);
      req(1, 64'h2804_0000);

      // R4: size A zero places device B at offset 0
      wr(0, 0);
      req(0, 64'h0);
      req(0, 64'h7F_FFFF);
      req(0, 64'h80_0000);
      req(1, 64'h2800_0004);

      // R10: writes to unused indices 6 and 7 change nothing
      wr(6, 64'hFFFF_FFFF);
      wr(7, 64'h3);
      req(0, 64'h0);
      req(0, 64'h80_0000);
      idle(3);

      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R7: missing results actual pending=%0d expected 0", sb.size());
      end
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7: watchdog expired actual running expected finished");
      finish_run();
   end
endmodule